// File: doc/BRIEF.md
# Corrected-Error Event Tracker

This block sits behind a memory controller's error-correction logic and receives at most one error report per clock: a valid strobe, the physical address the report concerns, and a flag for an uncorrectable error. Every corrected report is counted in a raw counter. Distinct failures are counted separately. A small fully associative table remembers recent failing addresses. A cell that is stuck and keeps reporting therefore produces one event and one alert, not a flood of them.

Each address in the table also keeps its own hit count. When that count reaches a set level, the block marks the address as a suspect location. When the number of distinct events rises above a threshold supplied by a register, the block raises a request to move data onto spare memory. The request stays set until it is cleared. Uncorrectable reports bypass all of this and produce an immediate machine-check pulse.

Top module: `cerr_tracker`

## Requirements
- R1: While `rst` is high and on the cycle after it is released, `raw_count` and `event_count` are 0, `new_event`, `mce`, `suspect` and `spare_req` are low, and the address table is empty.
- R2: A corrected report (`rpt_valid` high, `rpt_fatal` low) raises `raw_count` by exactly one, visible on the cycle after the report.
- R3: `raw_count` stops at its largest value (255 with default parameters) and does not wrap.
- R4: A corrected report for an address not held in the table pulses `new_event` high for one cycle and raises `event_count` by one, both on the cycle after the report.
- R5: A corrected report for an address already in the table leaves `event_count` unchanged and gives no `new_event` pulse. It still counts in `raw_count`.
- R6: The table holds ENTRIES addresses (8 by default) and fills slots in order. Once it is full, each new address overwrites the slots in round-robin order, starting with the one filled first. A report for an evicted address counts as a new event.
- R7: When the hit count of a table address reaches SUSPECT_HITS (4 by default, the first report counting as 1), `suspect` pulses for one cycle on the cycle after that report. `suspect_addr` carries that address. Later reports for the same address do not pulse it again.
- R8: `spare_req` goes high on the cycle after a new event that brings `event_count` above `thresh`. It stays high until a cycle in which `spare_clr` is high and no such event occurs. If the event and the clear arrive together, the set wins.
- R9: An uncorrectable report (`rpt_valid` and `rpt_fatal` both high) pulses `mce` on the next cycle. It changes neither counter, the table, `new_event` nor `suspect`.
- R10: With `rpt_valid` low, no counter, pulse or table entry changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rpt_valid | input | 1 | A report is present this cycle |
| rpt_fatal | input | 1 | 1 = uncorrectable, 0 = corrected |
| rpt_addr | input | ADDR_W | Physical address of the report |
| thresh | input | EVT_W | Distinct-event threshold for the spare request |
| spare_clr | input | 1 | Clears the spare request |
| raw_count | output | RAW_W | Saturating count of corrected reports |
| event_count | output | EVT_W | Saturating count of distinct events |
| new_event | output | 1 | One-cycle alert for a new distinct event |
| suspect | output | 1 | One-cycle pulse: an address reached the suspect level |
| suspect_addr | output | ADDR_W | Address behind the latest `suspect` pulse |
| spare_req | output | 1 | Sticky request to move data onto spare memory |
| mce | output | 1 | One-cycle machine-check pulse |

## Verification
All results are registered once, so every output is due on the cycle after the edge that captures a report. The bench drives a report at a falling edge and lets one rising edge capture it. At the following falling edge it compares all outputs, then drives the next report. Sticky and saturating behaviour is checked after runs that are long enough to hit each limit. For eviction, the table is filled, one address past its size is added, and the bench then checks which earlier addresses still count as repeats.

// File: rtl/cerr_pkg.sv
package cerr_pkg;

    // Classification of the report arriving in a cycle
    typedef enum logic [1:0] {
        RPT_IDLE  = 2'd0,
        RPT_CORR  = 2'd1,
        RPT_FATAL = 2'd2
    } rpt_kind_e;

    localparam int DEF_ADDR_W  = 32;
    localparam int DEF_ENTRIES = 8;
    localparam int DEF_HIT_W   = 4;
    localparam int DEF_RAW_W   = 8;
    localparam int DEF_EVT_W   = 8;

    function automatic rpt_kind_e classify(input logic vld, input logic fatal);
        if (!vld)
            return RPT_IDLE;
        else if (fatal)
            return RPT_FATAL;
        else
            return RPT_CORR;
    endfunction

endpackage

// File: rtl/cerr_sat_ctr.sv
module cerr_sat_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (inc && count != TOP)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/cerr_dedup_table.sv
module cerr_dedup_table #(
    parameter int ADDR_W       = 32,
    parameter int ENTRIES      = 8,
    parameter int HIT_W        = 4,
    parameter int SUSPECT_HITS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic              reached
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [HIT_W-1:0] HIT_TOP = {HIT_W{1'b1}};

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] tag;
        logic [HIT_W-1:0]  hits;
    } entry_t;

    entry_t             tbl [ENTRIES];
    logic [ENTRIES-1:0] match;
    logic [HIT_W-1:0]   hit_hits;
    logic [IDX_W-1:0]   victim;

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_ent
            assign match[g] = tbl[g].vld && (tbl[g].tag == addr);

            always_ff @(posedge clk) begin
                if (rst) begin
                    tbl[g] <= '0;
                end else if (upd) begin
                    if (match[g]) begin
                        if (tbl[g].hits != HIT_TOP)
                            tbl[g].hits <= tbl[g].hits + 1'b1;
                    end else if (!hit && victim == IDX_W'(g)) begin
                        tbl[g] <= '{vld: 1'b1, tag: addr, hits: HIT_W'(1)};
                    end
                end
            end
        end
    endgenerate

    assign hit = |match;

    always_comb begin
        hit_hits = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (match[i])
                hit_hits = hit_hits | tbl[i].hits;
    end

    // Suspect level is hit exactly once: on the update that brings the count to it
    always_comb begin
        if (!upd)
            reached = 1'b0;
        else if (hit)
            reached = (hit_hits != HIT_TOP) &&
                      ({1'b0, hit_hits} + 1'b1 == (HIT_W+1)'(SUSPECT_HITS));
        else
            reached = (SUSPECT_HITS == 1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            victim <= '0;
        else if (upd && !hit)
            victim <= (victim == IDX_W'(ENTRIES-1)) ? '0 : victim + 1'b1;
    end
endmodule

// File: rtl/cerr_tracker.sv
module cerr_tracker
    import cerr_pkg::*;
#(
    parameter int ADDR_W       = DEF_ADDR_W,
    parameter int ENTRIES      = DEF_ENTRIES,
    parameter int HIT_W        = DEF_HIT_W,
    parameter int SUSPECT_HITS = 4,
    parameter int RAW_W        = DEF_RAW_W,
    parameter int EVT_W        = DEF_EVT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rpt_valid,
    input  logic              rpt_fatal,
    input  logic [ADDR_W-1:0] rpt_addr,
    input  logic [EVT_W-1:0]  thresh,
    input  logic              spare_clr,
    output logic [RAW_W-1:0]  raw_count,
    output logic [EVT_W-1:0]  event_count,
    output logic              new_event,
    output logic              suspect,
    output logic [ADDR_W-1:0] suspect_addr,
    output logic              spare_req,
    output logic              mce
);
    localparam logic [EVT_W-1:0] EVT_TOP = {EVT_W{1'b1}};

    rpt_kind_e        kind;
    logic             corr;
    logic             tbl_hit;
    logic             tbl_reached;
    logic             fresh;
    logic [EVT_W-1:0] evt_after;

    assign kind  = classify(rpt_valid, rpt_fatal);
    assign corr  = (kind == RPT_CORR);
    assign fresh = corr && !tbl_hit;
    assign evt_after = (event_count == EVT_TOP) ? EVT_TOP : event_count + 1'b1;

    cerr_dedup_table #(
        .ADDR_W      (ADDR_W),
        .ENTRIES     (ENTRIES),
        .HIT_W       (HIT_W),
        .SUSPECT_HITS(SUSPECT_HITS)
    ) u_table (
        .clk    (clk),
        .rst    (rst),
        .upd    (corr),
        .addr   (rpt_addr),
        .hit    (tbl_hit),
        .reached(tbl_reached)
    );

    cerr_sat_ctr #(.W(RAW_W)) u_raw (
        .clk  (clk),
        .rst  (rst),
        .inc  (corr),
        .count(raw_count)
    );

    cerr_sat_ctr #(.W(EVT_W)) u_evt (
        .clk  (clk),
        .rst  (rst),
        .inc  (fresh),
        .count(event_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            new_event    <= 1'b0;
            suspect      <= 1'b0;
            suspect_addr <= '0;
            spare_req    <= 1'b0;
            mce          <= 1'b0;
        end else begin
            new_event <= fresh;
            mce       <= (kind == RPT_FATAL);
            suspect   <= tbl_reached;
            if (tbl_reached)
                suspect_addr <= rpt_addr;
            if (fresh && evt_after > thresh)
                spare_req <= 1'b1;
            else if (spare_clr)
                spare_req <= 1'b0;
        end
    end
endmodule

// File: rtl/cerr_tracker_chk.sv
module cerr_tracker_chk #(
    parameter int RAW_W = 8,
    parameter int EVT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             rpt_valid,
    input logic             rpt_fatal,
    input logic             spare_clr,
    input logic [RAW_W-1:0] raw_count,
    input logic [EVT_W-1:0] event_count,
    input logic             new_event,
    input logic             suspect,
    input logic             spare_req,
    input logic             mce
);
    // R9
    mce_src_chk: assert property (@(posedge clk) disable iff (rst)
        mce |-> $past(rpt_valid && rpt_fatal));

    // R9
    fatal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (rpt_valid && rpt_fatal) |=> ($stable(raw_count) && $stable(event_count)
                                      && !new_event && !suspect));

    // R2
    raw_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(raw_count) |-> (raw_count - $past(raw_count)) == RAW_W'(1));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rpt_valid |=> ($stable(raw_count) && $stable(event_count)
                        && !new_event && !mce && !suspect));

    // R5
    no_alert_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !new_event |-> $stable(event_count));

    // R7
    suspect_src_chk: assert property (@(posedge clk) disable iff (rst)
        suspect |-> $past(rpt_valid && !rpt_fatal));

    // R8
    spare_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(spare_req) |-> new_event);

    // R8
    spare_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(spare_req) |-> $past(spare_clr));

    // R4
    pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(new_event && mce));
endmodule

bind cerr_tracker cerr_tracker_chk #(
    .RAW_W(RAW_W),
    .EVT_W(EVT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rpt_valid  (rpt_valid),
    .rpt_fatal  (rpt_fatal),
    .spare_clr  (spare_clr),
    .raw_count  (raw_count),
    .event_count(event_count),
    .new_event  (new_event),
    .suspect    (suspect),
    .spare_req  (spare_req),
    .mce        (mce)
);

// File: tb/cerr_tracker_bench.sv
module cerr_tracker_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rpt_valid = 1'b0;
    logic        rpt_fatal = 1'b0;
    logic [31:0] rpt_addr = '0;
    logic [7:0]  thresh = 8'd3;
    logic        spare_clr = 1'b0;
    logic [7:0]  raw_count;
    logic [7:0]  event_count;
    logic        new_event;
    logic        suspect;
    logic [31:0] suspect_addr;
    logic        spare_req;
    logic        mce;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cerr_tracker u_cerr_tracker (
        .clk(clk), .rst(rst), .rpt_valid(rpt_valid), .rpt_fatal(rpt_fatal),
        .rpt_addr(rpt_addr), .thresh(thresh), .spare_clr(spare_clr),
        .raw_count(raw_count), .event_count(event_count), .new_event(new_event),
        .suspect(suspect), .suspect_addr(suspect_addr), .spare_req(spare_req),
        .mce(mce)
    );

    typedef struct packed {
        logic        vld;
        logic        fat;
        logic [31:0] addr;
        logic        nw;
        logic        mc;
        logic        sus;
        logic        spr;
        logic [7:0]  raw;
        logic [7:0]  evt;
    } vec_t;

    localparam int NV = 11;
    // Threshold 3, suspect level 4
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 32'h100, 1'b1, 1'b0, 1'b0, 1'b0, 8'd1, 8'd1}, // R4 first sight
        '{1'b0, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 1'b0, 8'd1, 8'd1}, // R10 idle
        '{1'b1, 1'b0, 32'h100, 1'b0, 1'b0, 1'b0, 1'b0, 8'd2, 8'd1}, // R5 repeat
        '{1'b1, 1'b1, 32'h200, 1'b0, 1'b1, 1'b0, 1'b0, 8'd2, 8'd1}, // R9 fatal
        '{1'b1, 1'b0, 32'h200, 1'b1, 1'b0, 1'b0, 1'b0, 8'd3, 8'd2}, // R9 fatal left no entry
        '{1'b1, 1'b0, 32'h100, 1'b0, 1'b0, 1'b0, 1'b0, 8'd4, 8'd2}, // R5
        '{1'b1, 1'b0, 32'h100, 1'b0, 1'b0, 1'b1, 1'b0, 8'd5, 8'd2}, // R7 fourth hit
        '{1'b1, 1'b0, 32'h300, 1'b1, 1'b0, 1'b0, 1'b0, 8'd6, 8'd3}, // R8 equal, not above
        '{1'b1, 1'b0, 32'h100, 1'b0, 1'b0, 1'b0, 1'b0, 8'd7, 8'd3}, // R7 no second pulse
        '{1'b1, 1'b0, 32'h400, 1'b1, 1'b0, 1'b0, 1'b1, 8'd8, 8'd4}, // R8 above threshold
        '{1'b1, 1'b1, 32'h400, 1'b0, 1'b1, 1'b0, 1'b1, 8'd8, 8'd4}  // R9 fatal
    };

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive one report at a falling edge; outputs are due at the next falling edge
    task automatic put(input logic v, input logic f, input logic [31:0] a);
        rpt_valid = v;
        rpt_fatal = f;
        rpt_addr  = a;
        @(negedge clk);
        rpt_valid = 1'b0;
        rpt_fatal = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic chk_zero(input string tag);
        chk("R1", {tag, " raw_count"}, raw_count, 0);
        chk("R1", {tag, " event_count"}, event_count, 0);
        chk("R1", {tag, " pulses"}, {new_event, mce, suspect, spare_req}, 0);
    endtask

    initial begin
        @(negedge clk);
        chk_zero("during reset");
        do_reset();
        chk_zero("after reset"); // R1

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            put(VEC[i].vld, VEC[i].fat, VEC[i].addr);
            chk("R2", $sformatf("vec %0d raw_count", i), raw_count, VEC[i].raw);
            chk("R4", $sformatf("vec %0d event_count", i), event_count, VEC[i].evt);
            chk("R5", $sformatf("vec %0d new_event", i), new_event, VEC[i].nw);
            chk("R9", $sformatf("vec %0d mce", i), mce, VEC[i].mc);
            chk("R7", $sformatf("vec %0d suspect", i), suspect, VEC[i].sus);
            if (VEC[i].sus)
                chk("R7", $sformatf("vec %0d suspect_addr", i), suspect_addr, VEC[i].addr);
            chk("R8", $sformatf("vec %0d spare_req", i), spare_req, VEC[i].spr);
        end

        // R8: a clear on its own drops the request
        spare_clr = 1'b1;
        @(negedge clk);
        spare_clr = 1'b0;
        chk("R8", "spare_req after clear", spare_req, 0);
        @(negedge clk);
        chk("R8", "spare_req stays clear", spare_req, 0);
        // R8: a new event together with a clear: the set wins
        spare_clr = 1'b1;
        put(1'b1, 1'b0, 32'h500);
        spare_clr = 1'b0;
        chk("R8", "set beats clear", spare_req, 1);
        chk("R4", "event_count 5", event_count, 5);

        // R1: reset from a busy state
        do_reset();
        chk_zero("mid-run reset");
        put(1'b1, 1'b0, 32'h100);
        chk("R1", "table empty after reset", new_event, 1);

        // R6: round-robin eviction
        do_reset();
        thresh = 8'hFF;
        for (int a = 1; a <= 8; a++)
            put(1'b1, 1'b0, 32'(a));
        chk("R6", "eight distinct", event_count, 8);
        put(1'b1, 1'b0, 32'd9);
        chk("R6", "ninth is new", new_event, 1);
        put(1'b1, 1'b0, 32'd1);
        chk("R6", "first slot evicted, addr 1 new", new_event, 1);
        put(1'b1, 1'b0, 32'd3);
        chk("R6", "addr 3 still held", new_event, 0);
        put(1'b1, 1'b0, 32'd2);
        chk("R6", "addr 2 evicted by addr 1", new_event, 1);
        chk("R6", "event_count 11", event_count, 11);
        chk("R8", "no request below threshold", spare_req, 0);

        // R3: raw counter saturation with one stuck address
        do_reset();
        for (int k = 0; k < 300; k++)
            put(1'b1, 1'b0, 32'hABC);
        chk("R3", "raw_count saturated", raw_count, 255);
        chk("R5", "stuck cell is one event", event_count, 1);
        put(1'b0, 1'b0, 32'h0);
        chk("R10", "idle keeps raw_count", raw_count, 255);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule